// File: doc/BRIEF.md
# Next Program Counter Unit

This block works out the next 16-bit program counter of a small 8-bit controller core, once per instruction. The decode stage presents the address of the current instruction, its length in bytes, a kind code that says how control flow goes on, the opcode and up to two operand bytes, the accumulator, the data pointer, a taken flag from the condition logic, and the two bytes a return has popped. One clock after a step strobe the unit shows the new program counter, the address of the following instruction (the value a call pushes), and a valid flag.

All targets are built from the address of the following instruction, which is the current address plus the length. Page jumps and calls replace the low eleven bits of that address and keep its top five bits. Long transfers take a full 16-bit operand. Relative branches add a signed byte. The indirect jump adds the accumulator to the data pointer. A return puts the popped bytes together. A combinational side output gives the code-memory address for table reads. All sums wrap at 65536 and no flag comes out of them.

Top module: `next_pc_unit`

## Requirements
- R1: While rst_n is low, pc_o and ret_o are 0x0000 and valid_o is 0.
- R2: valid_o is 1 exactly in the cycle after a cycle with step_i high. When step_i is low, pc_o and ret_o keep their values.
- R3: After a step, ret_o equals pc_i + len_i modulo 65536, whatever the kind.
- R4: Kind 0 (sequential) and the unused kinds 6 and 7 give pc_o = pc_i + len_i. taken_i has no effect on them.
- R5: Kind 1 (page jump or call; opcode low nibble must be 0001) gives pc_o = {next[15:11], opcode_i[7:5], byte1_i}, where next = pc_i + len_i. The top five bits come from the following instruction's address even when that address lies in the next 2K page.
- R6: Kind 2 (long jump or call) gives pc_o = {byte1_i, byte2_i}, with the high byte first.
- R7: Kind 3 (relative branch) with taken_i high gives pc_o = next + sign-extended offset, modulo 65536. The offset is byte2_i when len_i is 3, and byte1_i otherwise.
- R8: Kind 3 with taken_i low gives pc_o = next.
- R9: Kind 4 (indirect jump) gives pc_o = dptr_i + acc_i modulo 65536.
- R10: Kind 5 (return) gives pc_o = {pop_hi_i, pop_lo_i}.
- R11: tbl_addr_o is combinational. It equals pc_i + 1 + acc_i when opcode_i[4] is 0, and dptr_i + acc_i when opcode_i[4] is 1, both modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Compute a new program counter this cycle |
| pc_i | input | 16 | Address of the current instruction |
| len_i | input | 2 | Instruction length in bytes (1 to 3) |
| kind_i | input | 3 | Flow kind: 0 seq, 1 page, 2 long, 3 relative, 4 indirect, 5 return |
| opcode_i | input | 8 | Opcode byte |
| byte1_i | input | 8 | First operand byte |
| byte2_i | input | 8 | Second operand byte |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| taken_i | input | 1 | Relative branch condition holds |
| pop_hi_i | input | 8 | High byte popped by a return |
| pop_lo_i | input | 8 | Low byte popped by a return |
| pc_o | output | 16 | New program counter |
| ret_o | output | 16 | Address of the following instruction |
| valid_o | output | 1 | pc_o and ret_o belong to the last step |
| tbl_addr_o | output | 16 | Code address for table reads |

## Verification
The hardest cases to reach are a page transfer whose following address has crossed into the next 2K page, and a three-byte relative branch whose two operand bytes would give different targets. The stimulus places a page call two bytes below a 2K boundary, so that only the post-instruction address gives the right upper bits. It also drives a three-byte branch with 0x80 in the first operand and 0x7F in the second, so that picking the wrong byte moves the target by 255. Wrap-around is reached with addresses and data pointers near 0xFFFF.

// File: rtl/next_pc_unit.sv
module next_pc_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        step_i,
  input  logic [15:0] pc_i,
  input  logic [1:0]  len_i,
  input  logic [2:0]  kind_i,
  input  logic [7:0]  opcode_i,
  input  logic [7:0]  byte1_i,
  input  logic [7:0]  byte2_i,
  input  logic [7:0]  acc_i,
  input  logic [15:0] dptr_i,
  input  logic        taken_i,
  input  logic [7:0]  pop_hi_i,
  input  logic [7:0]  pop_lo_i,
  output logic [15:0] pc_o,
  output logic [15:0] ret_o,
  output logic        valid_o,
  output logic [15:0] tbl_addr_o
);
  localparam logic [2:0] K_SEQ  = 3'd0;
  localparam logic [2:0] K_PAGE = 3'd1;
  localparam logic [2:0] K_LONG = 3'd2;
  localparam logic [2:0] K_REL  = 3'd3;
  localparam logic [2:0] K_IND  = 3'd4;
  localparam logic [2:0] K_RET  = 3'd5;

  logic [15:0] next_seq, target;
  logic [7:0]  rel_off;

  assign next_seq   = pc_i + {14'd0, len_i};
  assign rel_off    = (len_i == 2'd3) ? byte2_i : byte1_i;
  assign tbl_addr_o = (opcode_i[4] ? dptr_i : pc_i + 16'd1) + {8'd0, acc_i};

  always_comb begin
    case (kind_i)
      K_PAGE:  target = {next_seq[15:11], opcode_i[7:5], byte1_i};
      K_LONG:  target = {byte1_i, byte2_i};
      K_REL:   target = taken_i ? next_seq + {{8{rel_off[7]}}, rel_off} : next_seq;
      K_IND:   target = dptr_i + {8'd0, acc_i};
      K_RET:   target = {pop_hi_i, pop_lo_i};
      default: target = next_seq;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o    <= 16'h0000;
      ret_o   <= 16'h0000;
      valid_o <= 1'b0;
    end else begin
      valid_o <= step_i;
      if (step_i) begin
        pc_o  <= target;
        ret_o <= next_seq;
      end
    end
  end

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> !valid_o && $stable(pc_o) && $stable(ret_o));

  assert_seq_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && (kind_i == K_SEQ || kind_i > K_RET) |=> pc_o == ret_o);

  assert_page_opcode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && kind_i == K_PAGE |-> opcode_i[3:0] == 4'b0001);

  assert_page_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && kind_i == K_PAGE |=> pc_o[15:11] == ret_o[15:11] && pc_o[7:0] == $past(byte1_i));

  assert_long_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && kind_i == K_LONG |=> pc_o == {$past(byte1_i), $past(byte2_i)});

  assert_not_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && kind_i == K_REL && !taken_i |=> pc_o == ret_o);

  assert_return_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && kind_i == K_RET |=> pc_o == {$past(pop_hi_i), $past(pop_lo_i)});
endmodule

// File: tb/test_next_pc_unit.sv
module test_next_pc_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, step_i = 0, taken_i = 0;
  logic [15:0] pc_i = 0, dptr_i = 0;
  logic [1:0]  len_i = 1;
  logic [2:0]  kind_i = 0;
  logic [7:0]  opcode_i = 0, byte1_i = 0, byte2_i = 0, acc_i = 0, pop_hi_i = 0, pop_lo_i = 0;
  logic [15:0] pc_o, ret_o, tbl_addr_o;
  logic        valid_o;

  int n_run = 0, n_fail = 0, cycles = 0;
  logic [15:0] q_pc[$], q_ret[$];
  string       q_tag[$];
  logic [15:0] last_pc, last_ret;

  always #(CLK_PERIOD/2) clk = ~clk;

  next_pc_unit i_next_pc_unit (.clk(clk), .rst_n(rst_n), .step_i(step_i), .pc_i(pc_i),
    .len_i(len_i), .kind_i(kind_i), .opcode_i(opcode_i), .byte1_i(byte1_i), .byte2_i(byte2_i),
    .acc_i(acc_i), .dptr_i(dptr_i), .taken_i(taken_i), .pop_hi_i(pop_hi_i), .pop_lo_i(pop_lo_i),
    .pc_o(pc_o), .ret_o(ret_o), .valid_o(valid_o), .tbl_addr_o(tbl_addr_o));

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] k, input logic [1:0] l, input logic [15:0] pc,
                       input logic [7:0] opc, input logic [7:0] b1, input logic [7:0] b2,
                       input logic [7:0] a, input logic [15:0] dp, input logic tk,
                       input logic [7:0] ph, input logic [7:0] pl, input string tag);
    logic [15:0] nxt, exp, tbl;
    logic [7:0] off;
    @(negedge clk);
    kind_i = k; len_i = l; pc_i = pc; opcode_i = opc; byte1_i = b1; byte2_i = b2;
    acc_i = a; dptr_i = dp; taken_i = tk; pop_hi_i = ph; pop_lo_i = pl; step_i = 1;
    nxt = pc + 16'(l);
    off = (l == 2'd3) ? b2 : b1;
    case (k)
      3'd1: exp = {nxt[15:11], opc[7:5], b1};
      3'd2: exp = {b1, b2};
      3'd3: exp = tk ? nxt + {{8{off[7]}}, off} : nxt;
      3'd4: exp = dp + 16'(a);
      3'd5: exp = {ph, pl};
      default: exp = nxt;
    endcase
    q_pc.push_back(exp); q_ret.push_back(nxt); q_tag.push_back(tag);
    last_pc = exp; last_ret = nxt;
    tbl = opc[4] ? dp + 16'(a) : pc + 16'd1 + 16'(a);
    #1 check("R11 table address", tbl_addr_o, tbl);
  endtask

  always @(negedge clk) if (rst_n && valid_o) begin
    if (q_pc.size() == 0) check("R2 unexpected valid", 16'd1, 16'd0);
    else begin
      check({q_tag[0], " pc"}, pc_o, q_pc[0]);
      check("R3 return address", ret_o, q_ret[0]);
      void'(q_pc.pop_front()); void'(q_ret.pop_front()); void'(q_tag.pop_front());
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      check("watchdog", 16'd1, 16'd0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc_o, 16'h0000);
    check("R1 reset ret", ret_o, 16'h0000);
    check("R1 reset valid", {15'd0, valid_o}, 16'd0);
    rst_n = 1;
    drive(3'd0, 2'd1, 16'h1234, 8'h00, 8'h00, 8'h00, 8'h05, 16'h2000, 1'b0, 8'h00, 8'h00, "R4 seq len1");
    drive(3'd0, 2'd3, 16'hFFFE, 8'h90, 8'h11, 8'h22, 8'h03, 16'h4000, 1'b1, 8'h00, 8'h00, "R4 seq wrap");
    drive(3'd7, 2'd2, 16'h0300, 8'h83, 8'h80, 8'h00, 8'hF0, 16'h0000, 1'b1, 8'h00, 8'h00, "R4 unused kind taken");
    drive(3'd1, 2'd2, 16'h0100, 8'hE1, 8'h34, 8'h00, 8'h01, 16'h0000, 1'b0, 8'h00, 8'h00, "R5 page jump");
    drive(3'd1, 2'd2, 16'h07FE, 8'h11, 8'h55, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, "R5 page call across 2K");
    drive(3'd1, 2'd2, 16'hF800, 8'h41, 8'hAA, 8'h00, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, "R5 page high block");
    drive(3'd2, 2'd3, 16'h0010, 8'h12, 8'hAB, 8'hCD, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, "R6 long call");
    drive(3'd3, 2'd2, 16'h0200, 8'h80, 8'h80, 8'h00, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h00, "R7 taken back 128");
    drive(3'd3, 2'd3, 16'h0200, 8'h20, 8'h80, 8'h7F, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h00, "R7 taken 3-byte offset");
    drive(3'd3, 2'd2, 16'hFFF0, 8'h40, 8'h20, 8'h00, 8'h00, 16'h0000, 1'b1, 8'h00, 8'h00, "R7 taken wrap");
    drive(3'd3, 2'd3, 16'h0400, 8'hB4, 8'h10, 8'h40, 8'h00, 16'h0000, 1'b0, 8'h00, 8'h00, "R8 not taken");
    drive(3'd4, 2'd1, 16'h0500, 8'h73, 8'h00, 8'h00, 8'h20, 16'hFFF0, 1'b1, 8'h00, 8'h00, "R9 indirect wrap");
    drive(3'd5, 2'd1, 16'h0600, 8'h22, 8'h00, 8'h00, 8'hFF, 16'hFFFF, 1'b0, 8'h12, 8'h34, "R10 return");
    @(negedge clk); step_i = 0; kind_i = 3'd2; byte1_i = 8'h99; byte2_i = 8'h88;
    repeat (3) @(negedge clk);
    check("R2 idle valid", {15'd0, valid_o}, 16'd0);
    check("R2 idle pc held", pc_o, last_pc);
    check("R2 idle ret held", ret_o, last_ret);
    check("R2 queue drained", 16'(q_pc.size()), 16'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule